// File: doc/BRIEF.md
# Serial Addressed Quad-Register Controller

This block is a three-wire serial slave that owns four 8-bit output registers. Each register normally shows a stored copy supplied by an external non-volatile array (`nv_i`). While chip select is high, a host shifts in framed commands. Each frame overrides the addressed register with a temporary value and returns that register's previous value on a tri-state data line. Every write is therefore also a destructive read. A read-only poll is a frame followed by dropping chip select, which restores the stored copy.

Dropping chip select reverts all four registers to their stored copies at once, and aborts any frame in progress. A program strobe sampled at the edge after the last data bit raises a one-cycle request toward the programming sequencer, carrying the channel and the value. Without that strobe the value is discarded. All serial inputs are synchronized into the block clock. Chip select also passes through a glitch filter, so short low pulses do not cause a revert.

Top module: `qrc_top`

## Requirements
- R1: Out of reset, with no serial clock activity, every channel output equals its stored copy on `nv_i`, `dout_oe_o` is 0 and `prog_req_o` stays 0.
- R2: A frame starts with a 1 on `di_i` at a rising `sclk_i` edge. It then carries two address bits and eight data bits, each LSB first. Zeros seen on `di_i` before a start bit are ignored.
- R3: Channel index is A0 + 2*A1 (A0 is the first address bit). Channel n occupies bits [8n+7:8n] of both `chan_o` and `nv_i`. A frame changes only the addressed channel.
- R4: After the edge that samples A1, `dout_o` shows bit 0 of the addressed channel's value before the frame. After the edge that samples data bit k, it shows bit k+1, for k = 0..6.
- R5: The addressed channel keeps its old value after the edge that samples D7. It takes the new value at the first rising `sclk_i` edge that follows D7.
- R6: `dout_oe_o` is 1 only while filtered chip select is high. `dout_o` is 0 whenever `dout_oe_o` is 0.
- R7: Filtered chip select going low reverts all four channels to `nv_i`.
- R8: If `prog_i` is high at the edge following D7, `prog_req_o` pulses for one clock with `prog_ch_o` set to the channel and `prog_data_o` to the value. Otherwise no request is made.
- R9: A frame cut short by chip select low updates nothing. The next frame after chip select returns high is parsed from its start bit.
- R10: A chip select low pulse shorter than `CS_FILT` clock cycles (after synchronization) causes no revert.
- R11: `di_i` is ignored at the two rising `sclk_i` edges after D7, so a 1 there does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| di_i | input | 1 | Serial data in |
| prog_i | input | 1 | Program strobe |
| nv_i | input | 32 | Stored copies, channel n at bits 8n+7:8n |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for dout_o |
| chan_o | output | 32 | Current channel values |
| prog_req_o | output | 1 | One-cycle program request |
| prog_ch_o | output | 2 | Channel of the program request |
| prog_data_o | output | 8 | Value of the program request |

## Verification
The assertions assume that `sclk_i`, `di_i` and `prog_i` change slowly relative to `clk_i`, so each serial level survives synchronization. They also assume that `di_i` and `prog_i` are settled several clocks before the serial clock rises. The stimulus holds every serial half period for at least four block clocks and changes data only while the serial clock is low. It also keeps chip select stable for ten clocks around each change, except in the single-clock glitch that is meant to be rejected.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_COMMIT,
    ST_GAP
  } frame_st_e;
endpackage

// File: rtl/qrc_sync.sv
module qrc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/qrc_cs_filter.sv
module qrc_cs_filter #(
  parameter int FILT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic cs_o
);
  localparam int CW = $clog2(FILT + 1);

  logic          cs_q;
  logic [CW-1:0] cnt_q;

  // level moves only after FILT consecutive cycles of disagreement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b0;
      cnt_q <= '0;
    end else if (cs_i == cs_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT - 1)) begin
      cs_q  <= cs_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cs_o = cs_q;

  p_glitch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> (!$past(cs_i, 1) && !$past(cs_i, 2)));
endmodule

// File: rtl/qrc_frame.sv
module qrc_frame
  import qrc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_high_i,
  input  logic                   sedge_i,
  input  logic                   di_i,
  input  logic                   prog_i,
  input  logic [NUM_CH*DW-1:0]   cur_i,
  output logic                   dout_o,
  output logic                   wr_en_o,
  output logic [$clog2(NUM_CH)-1:0] wr_idx_o,
  output logic [DW-1:0]          wr_data_o,
  output logic                   prog_req_o
);
  localparam int AW = $clog2(NUM_CH);
  localparam int BW = $clog2(DW);

  frame_st_e         state_q, state_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [AW-1:0]     addr_q, addr_d, addr_full;
  logic [DW-1:0]     data_q, data_d;
  logic [DW-1:0]     shift_q, shift_d;
  logic              wr_en_d, prog_req_d;

  // address as it stands once the current bit is included
  assign addr_full = {di_i, addr_q[AW-1:1]};

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    addr_d     = addr_q;
    data_d     = data_q;
    shift_d    = shift_q;
    wr_en_d    = 1'b0;
    prog_req_d = 1'b0;
    if (!cs_high_i) begin
      state_d = ST_IDLE;
    end else if (sedge_i) begin
      unique case (state_q)
        ST_IDLE: if (di_i) begin
          state_d = ST_ADDR;
          bit_d   = '0;
        end
        ST_ADDR: begin
          addr_d = addr_full;
          if (bit_q == BW'(AW - 1)) begin
            shift_d = cur_i[addr_full*DW +: DW];
            bit_d   = '0;
            state_d = ST_DATA;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        ST_DATA: begin
          data_d  = {di_i, data_q[DW-1:1]};
          shift_d = {1'b0, shift_q[DW-1:1]};
          if (bit_q == BW'(DW - 1)) state_d = ST_COMMIT;
          else bit_d = bit_q + 1'b1;
        end
        ST_COMMIT: begin
          wr_en_d    = 1'b1;
          prog_req_d = prog_i;
          state_d    = ST_GAP;
        end
        ST_GAP:  state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      shift_q    <= '0;
      wr_en_o    <= 1'b0;
      prog_req_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_q      <= bit_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
      shift_q    <= shift_d;
      wr_en_o    <= wr_en_d;
      prog_req_o <= prog_req_d;
    end
  end

  assign dout_o    = (state_q == ST_DATA) & shift_q[0];
  assign wr_idx_o  = addr_q;
  assign wr_data_o = data_q;

  p_prog_with_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> wr_en_o);
  p_gap_to_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && sedge_i) |=> state_q == ST_IDLE);
  p_no_start_in_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COMMIT && sedge_i && cs_high_i) |=> state_q == ST_GAP);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_high_i |=> (state_q == ST_IDLE && !wr_en_o));
endmodule

// File: rtl/qrc_bank.sv
module qrc_bank #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_high_i,
  input  logic                      wr_en_i,
  input  logic [$clog2(NUM_CH)-1:0] wr_idx_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [NUM_CH*DW-1:0]      nv_i,
  output logic [NUM_CH*DW-1:0]      chan_o
);
  localparam int AW = $clog2(NUM_CH);

  logic [NUM_CH-1:0] ovr_q;
  logic [NUM_CH-1:0] hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DW-1:0] vol_q;

    assign hit[g] = wr_en_i && (wr_idx_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ovr_q[g] <= 1'b0;
        vol_q    <= '0;
      end else if (!cs_high_i) begin
        ovr_q[g] <= 1'b0;
      end else if (hit[g]) begin
        ovr_q[g] <= 1'b1;
        vol_q    <= wr_data_i;
      end
    end

    // stored copy shows through unless a temporary value overrides it
    assign chan_o[g*DW +: DW] = ovr_q[g] ? vol_q : nv_i[g*DW +: DW];
  end

  p_one_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  p_revert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_high_i |=> (ovr_q == '0));
  p_reset_stored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q == '0) |-> (chan_o == nv_i));
endmodule

// File: rtl/qrc_top.sv
module qrc_top #(
  parameter int NUM_CH      = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CS_FILT     = 3,
  localparam int AW         = $clog2(NUM_CH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 cs_i,
  input  logic                 di_i,
  input  logic                 prog_i,
  input  logic [NUM_CH*DW-1:0] nv_i,
  output logic                 dout_o,
  output logic                 dout_oe_o,
  output logic [NUM_CH*DW-1:0] chan_o,
  output logic                 prog_req_o,
  output logic [AW-1:0]        prog_ch_o,
  output logic [DW-1:0]        prog_data_o
);
  logic       sclk_s, cs_s, di_s, prog_s;
  logic       sclk_d, sedge, cs_high, dout_raw;
  logic       wr_en;
  logic [AW-1:0] wr_idx;
  logic [DW-1:0] wr_data;

  qrc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_i, di_i, prog_i}),
    .q_o   ({sclk_s, cs_s, di_s, prog_s})
  );

  qrc_cs_filter #(.FILT(CS_FILT)) u_cs_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (cs_s),
    .cs_o  (cs_high)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign sedge = sclk_s & ~sclk_d;

  qrc_frame #(.NUM_CH(NUM_CH), .DW(DW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_high_i (cs_high),
    .sedge_i   (sedge),
    .di_i      (di_s),
    .prog_i    (prog_s),
    .cur_i     (chan_o),
    .dout_o    (dout_raw),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .prog_req_o(prog_req_o)
  );

  qrc_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_high_i(cs_high),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .nv_i     (nv_i),
    .chan_o   (chan_o)
  );

  assign dout_oe_o   = cs_high;
  assign dout_o      = cs_high & dout_raw;
  assign prog_ch_o   = wr_idx;
  assign prog_data_o = wr_data;

  p_dout_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> !dout_o);
  p_oe_needs_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> $past(cs_s));
endmodule

// File: tb/qrc_top_bench.sv
module qrc_top_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs = 1'b0, di = 1'b0, prog = 1'b0;
  logic [31:0] nv_vec;
  logic        dout, dout_oe, prog_req;
  logic [31:0] chan;
  logic [1:0]  prog_ch;
  logic [7:0]  prog_data;

  item_t       exp_q[$];
  int          n_chk = 0, n_fail = 0;
  int          prog_cnt = 0, prog_cnt_m = 0;
  logic [9:0]  last_req = '0;
  logic [7:0]  nv_m[4], cur_m[4];
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrc_top u_qrc_top (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .di_i(di),
    .prog_i(prog), .nv_i(nv_vec), .dout_o(dout), .dout_oe_o(dout_oe),
    .chan_o(chan), .prog_req_o(prog_req), .prog_ch_o(prog_ch),
    .prog_data_o(prog_data)
  );

  // bench acts as storage array: accepted requests rewrite the stored copy
  always @(posedge clk) if (prog_req) begin
    prog_cnt++;
    last_req = {prog_ch, prog_data};
    nv_vec[prog_ch*8 +: 8] <= prog_data;
  end

  function automatic logic [31:0] observe(int kind, int idx);
    case (kind)
      0: return {31'b0, dout};
      1: return {31'b0, dout_oe};
      2: return {24'b0, chan[idx*8 +: 8]};
      3: return 32'(prog_cnt);
      default: return {22'b0, last_req};
    endcase
  endfunction

  initial forever begin
    item_t it;
    logic [31:0] got;
    wait (exp_q.size() != 0);
    it  = exp_q.pop_front();
    got = observe(it.kind, it.idx);
    n_chk++;
    if (got !== it.exp) begin
      n_fail++;
      $display("FAIL %s: got %h exp %h", it.tag, got, it.exp);
    end
  end

  task automatic expect_v(int kind, int idx, logic [31:0] v, string tag);
    exp_q.push_back('{kind, idx, v, tag});
  endtask

  task automatic bit_edge(logic b);
    di = b;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic check_all_chans(string tag);
    for (int c = 0; c < 4; c++) expect_v(2, c, {24'b0, cur_m[c]}, tag);
  endtask

  task automatic frame(logic [1:0] idx, logic [7:0] d, bit do_prog, logic gap_bit);
    logic [7:0] old = cur_m[idx];
    bit_edge(1'b1);
    bit_edge(idx[0]);
    bit_edge(idx[1]);
    expect_v(0, 0, {31'b0, old[0]}, "R4 dout bit0 after A1");
    for (int k = 0; k < 8; k++) begin
      bit_edge(d[k]);
      if (k < 7) expect_v(0, 0, {31'b0, old[k+1]}, "R4 dout shifted bit");
    end
    expect_v(2, idx, {24'b0, old}, "R5 old value held after D7");
    if (do_prog) prog = 1'b1;
    bit_edge(gap_bit);
    prog = 1'b0;
    cur_m[idx] = d;
    if (do_prog) begin
      nv_m[idx] = d;
      prog_cnt_m++;
    end
    expect_v(2, idx, {24'b0, d}, "R5 new value after commit edge");
    expect_v(3, 0, 32'(prog_cnt_m), "R8 program request count");
    if (do_prog) expect_v(4, 0, {22'b0, idx, d}, "R8 program request payload");
    bit_edge(gap_bit);
    check_all_chans("R3 only addressed channel changed");
  endtask

  task automatic set_cs(logic v);
    cs = v;
    repeat (10) @(negedge clk);
    if (!v) for (int c = 0; c < 4; c++) cur_m[c] = nv_m[c];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    nv_m = '{8'h0F, 8'h81, 8'h5A, 8'hC3};
    for (int c = 0; c < 4; c++) cur_m[c] = nv_m[c];
    nv_vec = {nv_m[3], nv_m[2], nv_m[1], nv_m[0]};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: stored copies visible with no serial clock
    check_all_chans("R1 stored value at power-up");
    expect_v(1, 0, 0, "R1 output enable low after reset");
    expect_v(3, 0, 0, "R1 no program request");

    set_cs(1'b1);
    expect_v(1, 0, 1, "R6 output enable with cs high");
    // R2: leading zeros ignored
    bit_edge(1'b0); bit_edge(1'b0); bit_edge(1'b0);
    check_all_chans("R2 zeros before start ignored");
    frame(2'd1, 8'hA5, 1'b0, 1'b0);
    frame(2'd2, 8'h3C, 1'b0, 1'b0);
    frame(2'd1, 8'h11, 1'b0, 1'b0);   // R4 destructive read of temp value

    // R10: one-cycle low pulse rejected
    cs = 1'b0;
    @(negedge clk);
    cs = 1'b1;
    repeat (10) @(negedge clk);
    expect_v(2, 1, 32'h11, "R10 glitch kept temporary value");
    expect_v(1, 0, 1, "R10 output enable stays high");

    frame(2'd3, 8'h7E, 1'b1, 1'b0);   // R8 program request
    frame(2'd0, 8'hF0, 1'b0, 1'b1);   // R11 ones in gap edges ignored
    frame(2'd0, 8'h0F, 1'b0, 1'b0);   // R11 next frame aligned

    // R9: abort mid-frame
    bit_edge(1'b1); bit_edge(1'b1); bit_edge(1'b0);
    bit_edge(1'b1); bit_edge(1'b0); bit_edge(1'b1);
    set_cs(1'b0);
    expect_v(1, 0, 0, "R6 output enable low with cs low");
    expect_v(0, 0, 0, "R6 dout quiet with cs low");
    check_all_chans("R7 revert to stored copies");
    expect_v(2, 3, 32'h7E, "R8 programmed value is stored copy");
    set_cs(1'b1);
    frame(2'd2, 8'h99, 1'b0, 1'b0);   // R9 parsed from start bit
    check_all_chans("R9 clean frame after abort");
    set_cs(1'b0);
    check_all_chans("R7 second revert");

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule